// File: doc/BRIEF.md
# Threshold FIFO Service Requester

This block places a small byte FIFO (16 entries by default) between a disk-side data engine and a host bus. It decides, cycle by cycle, whether the host should be asked to move data. The decision uses a programmable threshold and follows a different watermark rule for each transfer direction. When data flows toward the host, the request asserts once enough bytes have gathered to fill the FIFO up to the threshold. When data flows toward the disk, the request asserts while there is room. The request then comes out either as an interrupt with a polled ready bit, or as a DMA request, depending on the signalling mode.

A command is framed by the execution-phase level. Its rising edge flushes the FIFO, clears the error flags and re-arms the requester. A terminal count withdraws the request for good. In DMA mode the count must be qualified by the acknowledge. The block signals that the result phase may start once the transfer has been ended and the FIFO is empty. With the FIFO switched off, the block acts as a one-byte buffer.

Top module: `fifo_svc_req`

## Requirements
- R1: After reset, irqOut, rqmOut, drqOut, resultOk, ovrFlag and udrFlag are 0 and fillLevel is 0.
- R2: Bytes leave the FIFO in the order they entered. A successful pop places the byte on rdByte on the same clock edge that lowers fillLevel.
- R3: In the toward-host direction (dirToHost=1), with T = cfgThrMinus1+1, the request sets on the edge where fillLevel reaches max(1, 16-T). It appears on irqOut and rqmOut when dmaMode=0, and on drqOut alone when dmaMode=1.
- R4: In the toward-host direction, a set request stays set until fillLevel becomes 0, and it clears on that edge.
- R5: In the toward-host direction, pushing a byte with sectorEnd=1 sets the request even when fillLevel is below the watermark.
- R6: In the toward-disk direction (dirToHost=0), the request sets on the edge that detects a rising execPhase and clears on the edge where fillLevel reaches 16.
- R7: In the toward-disk direction, after the request has cleared at full, it sets again on the edge where fillLevel falls to T or below.
- R8: In DMA mode, toward the disk, tcIn=1 with dackN=0 ends the transfer: drqOut drops on that edge and stays 0 until the next rising execPhase.
- R9: In DMA mode, toward the host, tcIn=1 ends the transfer on a falling dackN, or on a falling hostRdN while dackN is already low. drqOut drops on that edge and stays 0 afterwards.
- R10: In non-DMA mode, tcIn=1 with dackN=1 ends the transfer: irqOut and rqmOut drop and stay 0.
- R11: resultOk is 1 only while execPhase=1, the transfer has ended, and fillLevel is 0.
- R12: A push into a full FIFO, or a pop from an empty one, changes neither fillLevel nor the stored data. It sets ovrFlag or udrFlag respectively. Each flag stays set until the next rising execPhase.
- R13: With cfgFifoOn=0 the FIFO holds one byte. Toward the host the request sets when that byte is present. Toward the disk the request is set exactly while the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgFifoOn | input | 1 | 1: full-depth FIFO, 0: one-byte buffer |
| cfgThrMinus1 | input | 4 | Threshold minus one |
| dirToHost | input | 1 | 1: disk to host, 0: host to disk |
| dmaMode | input | 1 | 1: DMA request signalling, 0: interrupt and ready bit |
| execPhase | input | 1 | Command execution phase; rising edge starts a command |
| diskPush | input | 1 | Disk engine writes diskData (toward host) |
| diskData | input | 8 | Byte from the disk engine |
| sectorEnd | input | 1 | With diskPush: last byte of a sector |
| diskPop | input | 1 | Disk engine takes a byte (toward disk) |
| hostRdN | input | 1 | Host read strobe, active low, acts on its falling edge |
| hostWrN | input | 1 | Host write strobe, active low, acts on its falling edge |
| hostData | input | 8 | Byte from the host |
| dackN | input | 1 | DMA acknowledge, active low |
| tcIn | input | 1 | Terminal count, active high |
| rdByte | output | 8 | Byte most recently popped |
| fillLevel | output | 5 | Bytes held in the FIFO |
| irqOut | output | 1 | Interrupt request (non-DMA mode) |
| rqmOut | output | 1 | Polled ready bit (non-DMA mode) |
| drqOut | output | 1 | DMA request |
| resultOk | output | 1 | Result phase may begin |
| ovrFlag | output | 1 | Sticky push-into-full flag |
| udrFlag | output | 1 | Sticky pop-from-empty flag |

## Verification
The bound checker watches several invariants on every cycle. No request is raised toward the host while the FIFO is empty, and none toward the disk while it is full. The mode split is checked: no interrupt in DMA mode. It also checks that the fill level moves by at most one except at a command start, that resultOk implies an empty FIFO, that the error flags stay sticky, and that the depth limit holds when the FIFO is disabled. Only the bench scenarios can show the threshold arithmetic, the sector-end flush, the re-arm point toward the disk, and the byte ordering. The same holds for the terminal-count and last-byte withdrawal, each of which depends on a specific strobe and acknowledge sequence.

// File: rtl/fifo_svc_pkg.sv
package fifo_svc_pkg;
  typedef struct packed {
    logic clear;     // flush pointers and level
    logic push;      // accepted write
    logic pop;       // accepted read
    logic fromHost;  // write data source
  } fifoCmd_t;
endpackage

// File: rtl/fifo_svc_dp.sv
module fifo_svc_dp
  import fifo_svc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoCmd_t          cmd,
  input  logic [DATA_W-1:0] diskData,
  input  logic [DATA_W-1:0] hostData,
  output logic [CNT_W-1:0]  count,
  output logic [DATA_W-1:0] rdByte
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [DATA_W-1:0] wrData;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign wrData = cmd.fromHost ? hostData : diskData;

  always_ff @(posedge clk) begin
    if (cmd.push && !cmd.clear) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      count  <= '0;
      rdByte <= '0;
    end else if (cmd.clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (cmd.push) wrPtr <= bump(wrPtr);
      if (cmd.pop) begin
        rdPtr  <= bump(rdPtr);
        rdByte <= mem[rdPtr];
      end
      if (cmd.push && !cmd.pop)      count <= count + CNT_W'(1);
      else if (cmd.pop && !cmd.push) count <= count - CNT_W'(1);
    end
  end
endmodule

// File: rtl/fifo_svc_ctl.sv
module fifo_svc_ctl
  import fifo_svc_pkg::*;
#(
  parameter int DEPTH  = 16,
  localparam int THR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgFifoOn,
  input  logic [THR_W-1:0] cfgThrMinus1,
  input  logic             dirToHost,
  input  logic             dmaMode,
  input  logic             execPhase,
  input  logic             diskPush,
  input  logic             sectorEnd,
  input  logic             diskPop,
  input  logic             hostRdN,
  input  logic             hostWrN,
  input  logic             dackN,
  input  logic             tcIn,
  input  logic [CNT_W-1:0] count,
  output fifoCmd_t         cmd,
  output logic             irqOut,
  output logic             rqmOut,
  output logic             drqOut,
  output logic             resultOk,
  output logic             ovrFlag,
  output logic             udrFlag
);
  logic execPrev, rdPrevN, wrPrevN, dackPrevN;
  logic reqQ, doneQ, flushQ;
  logic execRise, rdFall, wrFall, dackFall, strobeFall;
  logic [CNT_W-1:0] effDepth, thrVal, markHost, markDisk, countNext;
  logic pushReq, popReq, isFull, isEmpty, pushOk, popOk;
  logic endHit, doneNext, flushNext, reqNext;

  // edge detection of sampled strobes
  assign execRise = execPhase & ~execPrev;
  assign rdFall   = rdPrevN & ~hostRdN;
  assign wrFall   = wrPrevN & ~hostWrN;
  assign dackFall = dackPrevN & ~dackN;
  assign strobeFall = dirToHost ? rdFall : wrFall;

  // watermarks
  assign effDepth = cfgFifoOn ? CNT_W'(DEPTH) : CNT_W'(1);
  assign thrVal   = CNT_W'(cfgThrMinus1) + CNT_W'(1);
  assign markHost = !cfgFifoOn ? CNT_W'(1)
                  : (thrVal >= CNT_W'(DEPTH)) ? CNT_W'(1) : CNT_W'(DEPTH) - thrVal;
  assign markDisk = cfgFifoOn ? thrVal : '0;

  // accepted transfers
  assign pushReq = dirToHost ? diskPush : wrFall;
  assign popReq  = dirToHost ? rdFall : diskPop;
  assign isFull  = (count >= effDepth);
  assign isEmpty = (count == '0);
  assign pushOk  = pushReq & ~isFull & ~execRise;
  assign popOk   = popReq & ~isEmpty & ~execRise;

  assign cmd.clear    = execRise;
  assign cmd.push     = pushOk;
  assign cmd.pop      = popOk;
  assign cmd.fromHost = ~dirToHost;

  always_comb begin
    countNext = count;
    if (execRise)              countNext = '0;
    else if (pushOk && !popOk) countNext = count + CNT_W'(1);
    else if (popOk && !pushOk) countNext = count - CNT_W'(1);
  end

  // end of transfer: qualified terminal count
  always_comb begin
    if (dmaMode) endHit = tcIn & ~dackN & (dackFall | strobeFall | ~dirToHost);
    else         endHit = tcIn & dackN;
  end

  assign doneNext  = execRise ? 1'b0 : (doneQ | endHit);
  assign flushNext = (execRise || countNext == '0) ? 1'b0
                   : (flushQ | (pushOk & sectorEnd & dirToHost));

  always_comb begin
    reqNext = 1'b0;
    if (execPhase && !doneNext) begin
      if (dirToHost)
        reqNext = reqQ ? (countNext != '0) : ((countNext >= markHost) || flushNext);
      else
        reqNext = reqQ ? (countNext < effDepth)
                       : ((countNext <= markDisk) && (countNext < effDepth));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      execPrev  <= 1'b0;
      rdPrevN   <= 1'b1;
      wrPrevN   <= 1'b1;
      dackPrevN <= 1'b1;
      reqQ      <= 1'b0;
      doneQ     <= 1'b0;
      flushQ    <= 1'b0;
      irqOut    <= 1'b0;
      rqmOut    <= 1'b0;
      drqOut    <= 1'b0;
      resultOk  <= 1'b0;
      ovrFlag   <= 1'b0;
      udrFlag   <= 1'b0;
    end else begin
      execPrev  <= execPhase;
      rdPrevN   <= hostRdN;
      wrPrevN   <= hostWrN;
      dackPrevN <= dackN;
      reqQ      <= reqNext;
      doneQ     <= doneNext;
      flushQ    <= flushNext;
      irqOut    <= reqNext & ~dmaMode;
      rqmOut    <= reqNext & ~dmaMode;
      drqOut    <= reqNext & dmaMode;
      resultOk  <= execPhase & doneNext & (countNext == '0);
      ovrFlag   <= execRise ? 1'b0 : (ovrFlag | (pushReq & isFull));
      udrFlag   <= execRise ? 1'b0 : (udrFlag | (popReq & isEmpty));
    end
  end
endmodule

// File: rtl/fifo_svc_req.sv
module fifo_svc_req
  import fifo_svc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int THR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgFifoOn,
  input  logic [THR_W-1:0]  cfgThrMinus1,
  input  logic              dirToHost,
  input  logic              dmaMode,
  input  logic              execPhase,
  input  logic              diskPush,
  input  logic [DATA_W-1:0] diskData,
  input  logic              sectorEnd,
  input  logic              diskPop,
  input  logic              hostRdN,
  input  logic              hostWrN,
  input  logic [DATA_W-1:0] hostData,
  input  logic              dackN,
  input  logic              tcIn,
  output logic [DATA_W-1:0] rdByte,
  output logic [CNT_W-1:0]  fillLevel,
  output logic              irqOut,
  output logic              rqmOut,
  output logic              drqOut,
  output logic              resultOk,
  output logic              ovrFlag,
  output logic              udrFlag
);
  fifoCmd_t cmd;

  fifo_svc_ctl #(.DEPTH(DEPTH)) u_ctl (
    .clk(clk), .rstN(rstN), .cfgFifoOn(cfgFifoOn), .cfgThrMinus1(cfgThrMinus1),
    .dirToHost(dirToHost), .dmaMode(dmaMode), .execPhase(execPhase),
    .diskPush(diskPush), .sectorEnd(sectorEnd), .diskPop(diskPop),
    .hostRdN(hostRdN), .hostWrN(hostWrN), .dackN(dackN), .tcIn(tcIn),
    .count(fillLevel), .cmd(cmd), .irqOut(irqOut), .rqmOut(rqmOut),
    .drqOut(drqOut), .resultOk(resultOk), .ovrFlag(ovrFlag), .udrFlag(udrFlag)
  );

  fifo_svc_dp #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .diskData(diskData),
    .hostData(hostData), .count(fillLevel), .rdByte(rdByte)
  );
endmodule

// File: rtl/fifo_svc_chk.sv
module fifo_svc_chk #(
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgFifoOn,
  input logic             dirToHost,
  input logic             dmaMode,
  input logic             execPhase,
  input logic [CNT_W-1:0] fillLevel,
  input logic             irqOut,
  input logic             rqmOut,
  input logic             drqOut,
  input logic             resultOk,
  input logic             ovrFlag,
  input logic             udrFlag
);
  logic anyReq;
  assign anyReq = irqOut | rqmOut | drqOut;

  p_dma_no_irq_r3: assert property (@(posedge clk) disable iff (!rstN)
    (dmaMode && $past(dmaMode)) |-> (!irqOut && !rqmOut));

  p_empty_no_req_r4: assert property (@(posedge clk) disable iff (!rstN)
    (dirToHost && $past(dirToHost) && fillLevel == '0) |-> !anyReq);

  p_full_no_req_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!dirToHost && !$past(dirToHost) && $past(cfgFifoOn)
     && fillLevel == CNT_W'(DEPTH)) |-> !anyReq);

  p_level_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    !$rose(execPhase) |=> (fillLevel == $past(fillLevel)
      || fillLevel == $past(fillLevel) + CNT_W'(1)
      || fillLevel + CNT_W'(1) == $past(fillLevel)));

  p_result_empty_r11: assert property (@(posedge clk) disable iff (!rstN)
    resultOk |-> (fillLevel == '0));

  p_ovr_sticky_r12: assert property (@(posedge clk) disable iff (!rstN)
    (ovrFlag && !$rose(execPhase)) |=> ovrFlag);

  p_udr_sticky_r12: assert property (@(posedge clk) disable iff (!rstN)
    (udrFlag && !$rose(execPhase)) |=> udrFlag);

  p_one_byte_r13: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgFifoOn && $past(!cfgFifoOn) && $past(fillLevel) <= CNT_W'(1))
      |-> (fillLevel <= CNT_W'(1)));
endmodule

bind fifo_svc_req fifo_svc_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .cfgFifoOn(cfgFifoOn), .dirToHost(dirToHost),
  .dmaMode(dmaMode), .execPhase(execPhase), .fillLevel(fillLevel),
  .irqOut(irqOut), .rqmOut(rqmOut), .drqOut(drqOut), .resultOk(resultOk),
  .ovrFlag(ovrFlag), .udrFlag(udrFlag)
);

// File: tb/fifo_svc_req_tb.sv
module fifo_svc_req_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgFifoOn = 1'b1;
  logic [3:0] cfgThrMinus1 = 4'd3;
  logic dirToHost = 1'b1, dmaMode = 1'b0, execPhase = 1'b0;
  logic diskPush = 1'b0, sectorEnd = 1'b0, diskPop = 1'b0;
  logic [7:0] diskData = 8'd0, hostData = 8'd0;
  logic hostRdN = 1'b1, hostWrN = 1'b1, dackN = 1'b1, tcIn = 1'b0;
  logic [7:0] rdByte;
  logic [4:0] fillLevel;
  logic irqOut, rqmOut, drqOut, resultOk, ovrFlag, udrFlag;

  int total = 0;
  int bad = 0;
  logic popLive = 1'b0;
  logic [7:0] expQ[$];
  logic [7:0] nextVal = 8'h40;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fifo_svc_req u_dut (
    .clk(clk), .rstN(rstN), .cfgFifoOn(cfgFifoOn), .cfgThrMinus1(cfgThrMinus1),
    .dirToHost(dirToHost), .dmaMode(dmaMode), .execPhase(execPhase),
    .diskPush(diskPush), .diskData(diskData), .sectorEnd(sectorEnd),
    .diskPop(diskPop), .hostRdN(hostRdN), .hostWrN(hostWrN), .hostData(hostData),
    .dackN(dackN), .tcIn(tcIn), .rdByte(rdByte), .fillLevel(fillLevel),
    .irqOut(irqOut), .rqmOut(rqmOut), .drqOut(drqOut), .resultOk(resultOk),
    .ovrFlag(ovrFlag), .udrFlag(udrFlag)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compare popped bytes against the expected queue (R2)
  always @(posedge clk) begin
    if (popLive) begin
      #(CLK_PERIOD / 4);
      total++;
      if (expQ.size() == 0) begin
        bad++;
        $display("FAIL R2 order: actual=%0d expected=none", rdByte);
      end else begin
        logic [7:0] e;
        e = expQ.pop_front();
        if (rdByte !== e) begin
          bad++;
          $display("FAIL R2 order: actual=%0d expected=%0d", rdByte, e);
        end
      end
    end
  end

  task automatic startCmd(input logic toHost, input logic dma, input logic on, input logic [3:0] thr);
    @(negedge clk);
    execPhase = 1'b0; dirToHost = toHost; dmaMode = dma; cfgFifoOn = on; cfgThrMinus1 = thr;
    @(negedge clk);
    execPhase = 1'b1;
    expQ.delete();
    @(negedge clk);
  endtask

  task automatic diskPushB(input logic eos, input logic ok);
    @(negedge clk);
    diskPush = 1'b1; diskData = nextVal; sectorEnd = eos;
    if (ok) expQ.push_back(nextVal);
    nextVal = nextVal + 8'd7;
    @(negedge clk);
    diskPush = 1'b0; sectorEnd = 1'b0;
  endtask

  task automatic hostWr(input logic ok);
    @(negedge clk);
    hostWrN = 1'b0; hostData = nextVal;
    if (ok) expQ.push_back(nextVal);
    nextVal = nextVal + 8'd5;
    @(negedge clk);
    hostWrN = 1'b1;
  endtask

  task automatic hostRd(input logic ok);
    @(negedge clk);
    hostRdN = 1'b0; popLive = ok;
    @(negedge clk);
    hostRdN = 1'b1; popLive = 1'b0;
  endtask

  task automatic diskPopB(input logic ok);
    @(negedge clk);
    diskPop = 1'b1; popLive = ok;
    @(negedge clk);
    diskPop = 1'b0; popLive = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 irqOut", irqOut, 0);
    chk("R1 drqOut", drqOut, 0);
    chk("R1 resultOk", resultOk, 0);
    chk("R1 flags", {ovrFlag, udrFlag}, 0);
    chk("R1 fillLevel", fillLevel, 0);
    rstN = 1'b1;

    // R3/R4: toward host, non-DMA, T=4 so watermark 12
    startCmd(1'b1, 1'b0, 1'b1, 4'd3);
    for (int i = 0; i < 11; i++) diskPushB(1'b0, 1'b1);
    chk("R3 irq below mark", irqOut, 0);
    diskPushB(1'b0, 1'b1);
    chk("R3 irq at mark", irqOut, 1);
    chk("R3 rqm at mark", rqmOut, 1);
    chk("R3 no drq in pio", drqOut, 0);
    for (int i = 0; i < 11; i++) hostRd(1'b1);
    chk("R4 irq held at 1 byte", irqOut, 1);
    hostRd(1'b1);
    chk("R4 irq cleared when empty", irqOut, 0);

    // R5: sector end flush in DMA mode
    startCmd(1'b1, 1'b1, 1'b1, 4'd3);
    diskPushB(1'b0, 1'b1);
    diskPushB(1'b0, 1'b1);
    chk("R5 drq before sector end", drqOut, 0);
    diskPushB(1'b1, 1'b1);
    chk("R5 drq after sector end", drqOut, 1);
    for (int i = 0; i < 3; i++) hostRd(1'b1);
    chk("R5 drq cleared when empty", drqOut, 0);

    // R9: last byte on read strobe with acknowledge already low
    startCmd(1'b1, 1'b1, 1'b1, 4'd3);
    @(negedge clk); dackN = 1'b0;
    for (int i = 0; i < 12; i++) diskPushB(1'b0, 1'b1);
    chk("R9 drq up", drqOut, 1);
    hostRd(1'b1);
    hostRd(1'b1);
    chk("R9 drq holds without tc", drqOut, 1);
    @(negedge clk); tcIn = 1'b1;
    hostRd(1'b1);
    tcIn = 1'b0;
    chk("R9 drq dropped on last byte", drqOut, 0);
    diskPushB(1'b0, 1'b1);
    chk("R9 drq stays down", drqOut, 0);
    dackN = 1'b1;

    // R6/R7/R8/R11: toward disk, DMA, T=4
    startCmd(1'b0, 1'b1, 1'b1, 4'd3);
    chk("R6 drq at exec entry", drqOut, 1);
    for (int i = 0; i < 15; i++) hostWr(1'b1);
    chk("R6 drq held below full", drqOut, 1);
    hostWr(1'b1);
    chk("R6 drq cleared at full", drqOut, 0);
    chk("R6 level full", fillLevel, 16);
    for (int i = 0; i < 11; i++) diskPopB(1'b1);
    chk("R7 drq off at 5", drqOut, 0);
    diskPopB(1'b1);
    chk("R7 drq back at 4", drqOut, 1);
    @(negedge clk); dackN = 1'b0; tcIn = 1'b1;
    @(negedge clk); dackN = 1'b1; tcIn = 1'b0;
    chk("R8 drq withdrawn by tc", drqOut, 0);
    chk("R11 not ready with data left", resultOk, 0);
    for (int i = 0; i < 3; i++) diskPopB(1'b1);
    chk("R11 not ready at 1 byte", resultOk, 0);
    diskPopB(1'b1);
    chk("R11 ready when empty", resultOk, 1);
    chk("R8 drq stays down", drqOut, 0);

    // R12 underrun, then R10
    diskPopB(1'b0);
    chk("R12 udr set", udrFlag, 1);
    chk("R12 level unchanged", fillLevel, 0);
    startCmd(1'b0, 1'b0, 1'b1, 4'd3);
    chk("R12 udr cleared by new command", udrFlag, 0);
    chk("R6 irq at exec entry", irqOut, 1);
    @(negedge clk); tcIn = 1'b1;
    @(negedge clk); tcIn = 1'b0;
    chk("R10 irq dropped by tc", irqOut, 0);
    chk("R10 rqm dropped by tc", rqmOut, 0);
    hostWr(1'b1);
    chk("R10 irq stays down", irqOut, 0);

    // R12 overrun
    startCmd(1'b1, 1'b0, 1'b1, 4'd3);
    for (int i = 0; i < 16; i++) diskPushB(1'b0, 1'b1);
    chk("R12 no ovr at full", ovrFlag, 0);
    diskPushB(1'b0, 1'b0);
    chk("R12 ovr set", ovrFlag, 1);
    chk("R12 level held", fillLevel, 16);
    for (int i = 0; i < 16; i++) hostRd(1'b1);
    chk("R12 ovr sticky", ovrFlag, 1);

    // R13 one-byte buffer
    startCmd(1'b1, 1'b0, 1'b0, 4'd3);
    chk("R13 no irq empty", irqOut, 0);
    diskPushB(1'b0, 1'b1);
    chk("R13 irq with one byte", irqOut, 1);
    diskPushB(1'b0, 1'b0);
    chk("R13 second byte ignored", fillLevel, 1);
    chk("R13 ovr on second byte", ovrFlag, 1);
    hostRd(1'b1);
    chk("R13 irq off empty", irqOut, 0);
    startCmd(1'b0, 1'b0, 1'b0, 4'd3);
    chk("R13 write irq when empty", irqOut, 1);
    hostWr(1'b1);
    chk("R13 write irq off when held", irqOut, 0);
    hostWr(1'b0);
    chk("R13 write level held", fillLevel, 1);
    diskPopB(1'b1);
    chk("R13 write irq back", irqOut, 1);

    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule